// File: doc/BRIEF.md
# Timestamp Interrupt Aggregator

This block gathers the interrupt sources of a precision-time unit into one sticky status vector with a per-bit enable vector. It produces a single summary event for the chip's interrupt controller. The sources are a transmit and a receive timestamp indication for each network port, a capture indication for each timestamp GPIO, and the event raised when the time counter matches its target. Each source is a one-cycle pulse that latches its status bit. The bit stays latched until the host clears it with a write-one-to-clear access.

A timestamp GPIO that is set up as an input also gives a hardware path for clearing the compare bit. The pin passes through two synchroniser stages and is then aligned to its configured active level. It must change from inactive to active and then stay active for a minimum time, derived from the clock period and a width in nanoseconds. Once it has done so, it clears the compare status bit once. Shorter pulses have no effect. Pins that are set up as outputs have no effect either.

Top module: `tsi_irq_agg`

## Requirements
- R1: After reset, `status_o`, `enable_o` and `summary_o` are all zero.
- R2: A 1 on bit k of `src_evt_i` sets bit k of `status_o` on the next clock edge, and the bit then stays set. Bit order: 2p is the port p transmit event and 2p+1 is the port p receive event. Bits 2·NUM_PORTS+g are the GPIO g capture events. The top bit (bit 6 by default) is the compare event.
- R3: A cycle with `clr_wr_i` high clears every status bit whose `clr_wdata_i` bit is 1. Bits written with 0 keep their value.
- R4: When a source pulse and a host clear hit the same bit in the same cycle, the bit ends up set.
- R5: A cycle with `en_wr_i` high loads `en_wdata_i` into `enable_o` on the next edge. Otherwise `enable_o` holds.
- R6: `summary_o` is 1 exactly when some bit is set in both `status_o` and `enable_o`. Changing the enables never changes `status_o`.
- R7: A GPIO input goes from its inactive level to its active level and stays active for at least QUAL = MIN_WIDTH_NS/CLK_PERIOD_NS + 1 clocks (6 by default, 48 ns > 40 ns). This clears the compare status bit and no other bit.
- R8: An active pulse of QUAL−1 clocks (5 by default) leaves the compare bit unchanged.
- R9: A pin whose `gpio_is_out_i` bit is 1 never clears the compare bit, whatever its level.
- R10: A `gpio_act_high_i` bit of 0 makes the pin active when low. A qualified low pulse then clears the compare bit.
- R11: A pin held active clears the compare bit only once. A compare event that arrives while the pin stays active remains latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt_i | input | NSRC (7) | One-cycle source event pulses |
| en_wr_i | input | 1 | Load strobe for the enable vector |
| en_wdata_i | input | NSRC | New enable vector |
| clr_wr_i | input | 1 | Host write-one-to-clear strobe |
| clr_wdata_i | input | NSRC | Bits to clear |
| gpio_i | input | NUM_GPIO (2) | Asynchronous timestamp GPIO levels |
| gpio_is_out_i | input | NUM_GPIO | 1 = pin driven as output, so its clear path is off |
| gpio_act_high_i | input | NUM_GPIO | 1 = active high, 0 = active low |
| status_o | output | NSRC | Sticky status bits |
| enable_o | output | NSRC | Enable vector |
| summary_o | output | 1 | OR of status bits ANDed with enables |

## Verification
A table of register-style steps drives single and multi-bit source pulses, partial and full clears, and a pulse and a clear landing on the same bit. It also changes the enables while status is fixed, which separates a status bit that really moved from one that only appears through the summary. Directed GPIO pulses of exactly QUAL and QUAL−1 clocks pin the filter threshold to the clock. Pulses of the same length on an output pin, on an active-low pin, and one held far beyond QUAL show whether direction, polarity and the single-shot rule are each honoured. Other status bits are kept set during these pulses to show the hardware clear touches only the compare bit.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  // Clocks a level must persist to exceed min_ns strictly.
  function automatic int unsigned tsi_qual_cycles(input int unsigned min_ns,
                                                  input int unsigned period_ns);
    return (min_ns / period_ns) + 1;
  endfunction

  // Total number of interrupt sources.
  function automatic int unsigned tsi_num_src(input int unsigned nports,
                                              input int unsigned ngpio);
    return 2 * nports + ngpio + 1;
  endfunction

  // Position of the compare event bit: always the top bit.
  function automatic int unsigned tsi_cmp_idx(input int unsigned nports,
                                              input int unsigned ngpio);
    return 2 * nports + ngpio;
  endfunction

endpackage

// File: rtl/tsi_gpio_filter.sv
module tsi_gpio_filter #(
  parameter int unsigned QUAL_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic is_out_i,
  input  logic act_high_i,
  output logic clr_o
);
  localparam int unsigned CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

  logic          sync1_q, sync2_q;
  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          clr_q, clr_d;
  logic          active;
  logic          fire;

  // Two-stage synchroniser.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
    end
  end

  assign active = act_high_i ? sync2_q : ~sync2_q;
  assign fire   = active && armed_q && !is_out_i && (cnt_q == LAST);

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    clr_d   = fire;
    if (is_out_i) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (!active) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (fire) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (armed_q) begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      clr_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      clr_q   <= clr_d;
    end
  end

  assign clr_o = clr_q;

  // R11: a qualified edge yields a single clear pulse
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q);

  // R9: an output pin produces no clear
  a_r9_output_silent: assert property (@(posedge clk) disable iff (!rst_n)
    is_out_i |=> !clr_q);

endmodule

// File: rtl/tsi_status_reg.sv
module tsi_status_reg #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] st_q, st_d;

  // Per-bit sticky cell: a set beats a clear in the same cycle.
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (set_i[i])      st_d[i] = 1'b1;
      else if (clr_i[i]) st_d[i] = 1'b0;
      else               st_d[i] = st_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign status_o = st_q;

  // R4: every pulsed source is set afterwards, even under a clear
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((st_q & $past(set_i)) == $past(set_i)));

  // R2: no bit rises without a source pulse
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(set_i)) == '0));

endmodule

// File: rtl/tsi_irq_agg.sv
module tsi_irq_agg
  import tsi_pkg::*;
#(
  parameter int unsigned NUM_PORTS     = 2,
  parameter int unsigned NUM_GPIO      = 2,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned MIN_WIDTH_NS  = 40,
  localparam int unsigned NSRC         = tsi_num_src(NUM_PORTS, NUM_GPIO)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     src_evt_i,
  input  logic                en_wr_i,
  input  logic [NSRC-1:0]     en_wdata_i,
  input  logic                clr_wr_i,
  input  logic [NSRC-1:0]     clr_wdata_i,
  input  logic [NUM_GPIO-1:0] gpio_i,
  input  logic [NUM_GPIO-1:0] gpio_is_out_i,
  input  logic [NUM_GPIO-1:0] gpio_act_high_i,
  output logic [NSRC-1:0]     status_o,
  output logic [NSRC-1:0]     enable_o,
  output logic                summary_o
);
  localparam int unsigned CMP  = tsi_cmp_idx(NUM_PORTS, NUM_GPIO);
  localparam int unsigned QUAL = tsi_qual_cycles(MIN_WIDTH_NS, CLK_PERIOD_NS);

  logic [NUM_GPIO-1:0] pin_clr;
  logic [NSRC-1:0]     hw_clr;
  logic [NSRC-1:0]     clr_vec;
  logic [NSRC-1:0]     en_q, en_d;

  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_pin
    tsi_gpio_filter #(.QUAL_CYC(QUAL)) u_filt (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (gpio_i[g]),
      .is_out_i   (gpio_is_out_i[g]),
      .act_high_i (gpio_act_high_i[g]),
      .clr_o      (pin_clr[g])
    );
  end

  always_comb begin
    hw_clr      = '0;
    hw_clr[CMP] = |pin_clr;
    clr_vec     = (clr_wr_i ? clr_wdata_i : '0) | hw_clr;
  end

  tsi_status_reg #(.W(NSRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (src_evt_i),
    .clr_i    (clr_vec),
    .status_o (status_o)
  );

  // Enable vector with explicit load enable.
  always_comb begin
    en_d = en_q;
    if (en_wr_i) en_d = en_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign enable_o  = en_q;
  assign summary_o = |(status_o & en_q);

  // R6: writing enables alone leaves the status vector untouched
  a_r6_mask_only: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_i && !clr_wr_i && (src_evt_i == '0) && (hw_clr == '0))
      |=> $stable(status_o));

  // R7: a hardware clear only ever removes the compare bit
  a_r7_hw_clear_target: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_clr != '0) && !clr_wr_i && (src_evt_i == '0))
      |=> ((status_o | (NSRC'(1) << CMP)) == ($past(status_o) | (NSRC'(1) << CMP))));

endmodule

// File: tb/tb_tsi_irq_agg.sv
module tb_tsi_irq_agg;
  localparam int CLK_PERIOD = 8;
  localparam int NS   = 7;
  localparam int QUAL = 40 / CLK_PERIOD + 1;
  localparam int NVEC = 10;

  // {src[30:24], clr_wr[23], clr[22:16], en_wr[15], en[14:8], exp_st[7:1], exp_sum[0]}
  localparam logic [30:0] VEC [NVEC] = '{
    {7'b0000001, 1'b0, 7'b0000000, 1'b0, 7'b0000000, 7'b0000001, 1'b0},
    {7'b0000000, 1'b0, 7'b0000000, 1'b1, 7'b0000010, 7'b0000001, 1'b0},
    {7'b0000010, 1'b0, 7'b0000000, 1'b0, 7'b0000000, 7'b0000011, 1'b1},
    {7'b0000000, 1'b1, 7'b0000001, 1'b0, 7'b0000000, 7'b0000010, 1'b1},
    {7'b1000000, 1'b1, 7'b1000010, 1'b0, 7'b0000000, 7'b1000000, 1'b0},
    {7'b0000000, 1'b0, 7'b0000000, 1'b1, 7'b1000000, 7'b1000000, 1'b1},
    {7'b0110100, 1'b0, 7'b0000000, 1'b0, 7'b0000000, 7'b1110100, 1'b1},
    {7'b0000000, 1'b1, 7'b1111111, 1'b0, 7'b0000000, 7'b0000000, 1'b0},
    {7'b0001000, 1'b0, 7'b0000000, 1'b1, 7'b1111111, 7'b0001000, 1'b1},
    {7'b0000000, 1'b1, 7'b0001000, 1'b0, 7'b0000000, 7'b0000000, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_evt, en_wdata, clr_wdata;
  logic          en_wr, clr_wr;
  logic [1:0]    gpio, gpio_is_out, gpio_act_high;
  logic [NS-1:0] status, enable;
  logic          summary;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tsi_irq_agg dut (
    .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt),
    .en_wr_i(en_wr), .en_wdata_i(en_wdata),
    .clr_wr_i(clr_wr), .clr_wdata_i(clr_wdata),
    .gpio_i(gpio), .gpio_is_out_i(gpio_is_out), .gpio_act_high_i(gpio_act_high),
    .status_o(status), .enable_o(enable), .summary_o(summary)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_src(input logic [NS-1:0] v);
    @(negedge clk) src_evt = v;
    @(negedge clk) src_evt = '0;
  endtask

  task automatic pin_pulse(input int idx, input logic lvl, input int cyc);
    @(negedge clk) gpio[idx] = lvl;
    idle(cyc - 1);
    @(negedge clk) gpio[idx] = ~lvl;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    src_evt = '0; en_wr = 1'b0; en_wdata = '0; clr_wr = 1'b0; clr_wdata = '0;
    gpio = 2'b10; gpio_is_out = 2'b00; gpio_act_high = 2'b01;
    idle(3);
    // R1: reset state
    check("R1 status", 32'(status), 0);
    check("R1 enable", 32'(enable), 0);
    check("R1 summary", 32'(summary), 0);
    @(negedge clk) rst_n = 1'b1;
    idle(4);

    // R2 R3 R4 R6: table of register steps
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      src_evt   = VEC[i][30:24];
      clr_wr    = VEC[i][23];
      clr_wdata = VEC[i][22:16];
      en_wr     = VEC[i][15];
      en_wdata  = VEC[i][14:8];
      @(negedge clk);
      check($sformatf("R2/R3/R4 status step %0d", i), 32'(status), 32'(VEC[i][7:1]));
      check($sformatf("R6 summary step %0d", i), 32'(summary), 32'(VEC[i][0]));
      src_evt = '0; clr_wr = 1'b0; en_wr = 1'b0;
    end

    // R5: enable load and hold
    @(negedge clk) begin en_wr = 1'b1; en_wdata = 7'b0100101; end
    @(negedge clk) en_wr = 1'b0;
    check("R5 enable load", 32'(enable), 32'h25);
    idle(2);
    check("R5 enable hold", 32'(enable), 32'h25);

    // R7: qualified active-high pulse clears only the compare bit
    @(negedge clk) begin en_wr = 1'b1; en_wdata = 7'b1000000; end
    @(negedge clk) en_wr = 1'b0;
    pulse_src(7'b1000001);
    check("R6 summary on compare", 32'(summary), 1);
    pin_pulse(0, 1'b1, QUAL);
    idle(10);
    check("R7 compare cleared", 32'(status), 32'h01);
    check("R7 summary drops", 32'(summary), 0);

    // R8: one clock short
    pulse_src(7'b1000000);
    pin_pulse(0, 1'b1, QUAL - 1);
    idle(10);
    check("R8 short pulse ignored", 32'(status), 32'h41);

    // R9: pin as output
    @(negedge clk) gpio_is_out[0] = 1'b1;
    pin_pulse(0, 1'b1, QUAL + 4);
    idle(10);
    check("R9 output pin ignored", 32'(status), 32'h41);
    @(negedge clk) gpio_is_out[0] = 1'b0;
    idle(4);

    // R10: active-low pin
    pin_pulse(1, 1'b0, QUAL);
    idle(10);
    check("R10 active-low clear", 32'(status), 32'h01);

    // R11: held-active pin clears only once
    pulse_src(7'b1000000);
    @(negedge clk) gpio[0] = 1'b1;
    idle(QUAL + 8);
    check("R11 first clear", 32'(status), 32'h01);
    pulse_src(7'b1000000);
    idle(QUAL + 8);
    check("R11 held pin no reclear", 32'(status), 32'h41);
    @(negedge clk) gpio[0] = 1'b0;
    idle(4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule